// File: doc/BRIEF.md
# DRAM page read command generator

This block writes a fixed program of sequencer command words into a command memory. The program reads one full DRAM page. It opens a row in a bank, issues a burst read at each of a run of columns and then closes the row. The sequencer that later runs the program lets the read data into its buffer while the reads are in flight, keeps the on-chip termination calibration enabled for the duration of the page, and resets its buffer pointer as the row closes.

A one-cycle `start` in the idle state captures the bank, row and starting column. The block then emits one word per cycle over a plain memory write port: address, data and write enable. Each word goes to the next address, counting up from a fixed base address plus an offset for the read block. `busy` stays high until the last word has been written. The program has two word kinds:

- A command word carries a DRAM address, a bank, a three-bit row/column/write-enable code and eleven control flags.
- A skip word carries a pause count, a done marker, a bank and the same flags.

Top module: `page_read_gen`

## Requirements
- R1: While reset is asserted and directly after it, `busy` and `wr_en` are low.
- R2: A `start` pulse while idle raises `busy` and `wr_en` after the next clock edge. They then stay high for exactly 4*NUM_READS+3 consecutive cycles (259 by default), one word per cycle, and then both go low.
- R3: The first word is written to BASE_ADDR+BLOCK_OFFSET, and each later word goes to the previous address plus one.
- R4: The word layout has these fields:
  - [31:17] address (skip words: pause count)
  - [16:14] bank
  - [13:11] code (0 marks a skip word)
  - [10:0] flags: bit10 termination enable, bit9 clock enable, bit8 select, bit7 data drive, bit6 strobe drive, bit5 strobe toggle, bit4 calibration enable, bit3 buffer write, bit2 buffer read, bit1 no-op (done marker in a skip word), bit0 buffer reset.

  Word 0 is an activate: code 4, the row in the address field, the captured bank and all flags 0.
- R5: Word 1 is a skip with count 1, bank 0 and flags 0.
- R6: Word 2 is a read: code 2, the address field holding the column, the captured bank and flags 0x118 (select, calibration, buffer write). Word 3 is a skip with count 0, the captured bank and flags 0x118.
- R7: For i = 1 to NUM_READS-1, word 4*i is a read. Its address field is the column plus i*8, computed 15 bits wide without wrapping at 10 bits. It carries the captured bank and flags 0x11A (no-op added).
- R8: Word 4*i+1 is a skip with count 0, the captured bank and flags 0x118. Words 4*i+2 and 4*i+3 are skips with count 0, the captured bank and flags 0x110 (buffer write cleared).
- R9: The program ends with three words:
  - a precharge: code 5, the row, the captured bank and flags 0x011 (calibration, buffer reset);
  - a skip with count 2, bank 0 and flags 0x010;
  - a skip with count 0, bank 0 and flags 0x002 (done).
- R10: `start` and changes on bank, row and column while `busy` is high have no effect on the words being emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a program (honoured only when idle) |
| bank | input | 3 | Bank to open |
| row | input | 15 | Row to open |
| col | input | 10 | Starting column |
| wr_addr | output | ADDR_W | Command memory write address |
| wr_data | output | 32 | Command or skip word |
| wr_en | output | 1 | Write strobe, one word per cycle |
| busy | output | 1 | High while the program is being written |

## Verification
The word index and the captured inputs alone determine every word. An index that slips by one cycle therefore shows at once on both the address and the data: a read's column field turns up where a skip was expected, or the address runs one ahead of the word. A capture register that reloads during a run corrupts the bank or column field of the very next word. A wrong end condition shows as `busy` falling one cycle early or late, next to a done word that is missing or repeated. The bench compares every word of three runs against an independently built list. That list includes a column whose read offsets pass 10 bits.

// File: rtl/page_read_gen.sv
module page_read_gen #(
  parameter int ADDR_W       = 10,
  parameter int BASE_ADDR    = 0,
  parameter int BLOCK_OFFSET = 128,
  parameter int NUM_READS    = 64,
  parameter int COL_STEP     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        bank,
  input  logic [14:0]       row,
  input  logic [9:0]        col,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              wr_en,
  output logic              busy
);
  localparam int LAST = 4*NUM_READS + 2;
  localparam int CW   = $clog2(LAST + 2);
  localparam logic [CW-1:0] IDX_LAST = CW'(LAST);
  localparam logic [CW-1:0] IDX_PRE  = CW'(4*NUM_READS);
  localparam logic [CW-1:0] IDX_GAP  = CW'(4*NUM_READS + 1);
  localparam logic [ADDR_W-1:0] START_ADDR = ADDR_W'(BASE_ADDR + BLOCK_OFFSET);
  localparam logic [10:0] F_RDW  = 11'h118;
  localparam logic [10:0] F_RDWN = 11'h11A;
  localparam logic [10:0] F_RD   = 11'h110;
  localparam logic [10:0] F_PRE  = 11'h011;
  localparam logic [10:0] F_CAL  = 11'h010;
  localparam logic [10:0] F_DONE = 11'h002;

  logic          busy_q;
  logic [CW-1:0] idx;
  logic [2:0]    ba_q;
  logic [14:0]   ra_q;
  logic [9:0]    ca_q;
  logic [14:0]   col_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx    <= '0;
      ba_q   <= '0;
      ra_q   <= '0;
      ca_q   <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        idx    <= '0;
        ba_q   <= bank;
        ra_q   <= row;
        ca_q   <= col;
      end
    end else begin
      if (idx == IDX_LAST) busy_q <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

  function automatic logic [31:0] word(input logic [14:0] a, input logic [2:0] b,
                                       input logic [2:0] c, input logic [10:0] f);
    return {a, b, c, f};
  endfunction

  assign col_sum = {5'b0, ca_q} + 15'(idx >> 2) * 15'(COL_STEP);

  always_comb begin
    if (idx == '0)                wr_data = word(ra_q, ba_q, 3'd4, 11'h0);
    else if (idx == CW'(1))       wr_data = word(15'd1, 3'd0, 3'd0, 11'h0);
    else if (idx == CW'(2))       wr_data = word({5'b0, ca_q}, ba_q, 3'd2, F_RDW);
    else if (idx == CW'(3))       wr_data = word(15'd0, ba_q, 3'd0, F_RDW);
    else if (idx < IDX_PRE) begin
      case (idx[1:0])
        2'd0:    wr_data = word(col_sum, ba_q, 3'd2, F_RDWN);
        2'd1:    wr_data = word(15'd0, ba_q, 3'd0, F_RDW);
        default: wr_data = word(15'd0, ba_q, 3'd0, F_RD);
      endcase
    end
    else if (idx == IDX_PRE)      wr_data = word(ra_q, ba_q, 3'd5, F_PRE);
    else if (idx == IDX_GAP)      wr_data = word(15'd2, 3'd0, 3'd0, F_CAL);
    else                          wr_data = word(15'd0, 3'd0, 3'd0, F_DONE);
  end

  assign wr_addr = START_ADDR + ADDR_W'(idx);
  assign wr_en   = busy_q;
  assign busy    = busy_q;

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> wr_addr == $past(wr_addr) + 1'b1);

  a_r3_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_addr == START_ADDR);

  a_r4_opens_with_activate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_data[13:11] == 3'd4);

  a_r9_done_is_last: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_data[13:11] == 3'd0 && wr_data[1] |=> !busy);

  a_r10_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(ba_q) && $stable(ra_q) && $stable(ca_q));
endmodule

// File: tb/sim_page_read_gen.sv
module sim_page_read_gen;
  localparam int CLK_P = 10;
  localparam int NR    = 64;
  localparam int NW    = 4*NR + 3;
  localparam logic [9:0] START_ADDR = 10'd128;

  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] bank = 0;
  logic [14:0] row = 0;
  logic [9:0] col = 0;
  logic [9:0] wr_addr;
  logic [31:0] wr_data;
  logic wr_en, busy;

  int checks = 0, errors = 0;
  logic [31:0] exp_w [NW];
  int wp;

  page_read_gen u0 (.clk(clk), .rst_n(rst_n), .start(start), .bank(bank), .row(row),
                    .col(col), .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en), .busy(busy));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input int a, input int b, input int c, input int f);
    exp_w[wp] = {a[14:0], b[2:0], c[2:0], f[10:0]};
    wp++;
  endtask

  task automatic build(input logic [2:0] ba, input logic [14:0] ra, input logic [9:0] ca);
    wp = 0;
    put(ra, ba, 4, 0);
    put(1, 0, 0, 0);
    put(ca, ba, 2, 'h118);
    put(0, ba, 0, 'h118);
    for (int i = 1; i < NR; i++) begin
      put(int'(ca) + i*8, ba, 2, 'h11A);
      put(0, ba, 0, 'h118);
      put(0, ba, 0, 'h110);
      put(0, ba, 0, 'h110);
    end
    put(ra, ba, 5, 'h011);
    put(2, 0, 0, 'h010);
    put(0, 0, 0, 'h002);
  endtask

  function automatic string tag_of(input int n);
    if (n == 0) return "R4";
    if (n == 1) return "R5";
    if (n < 4) return "R6";
    if (n < 4*NR) return (n % 4 == 0) ? "R7" : "R8";
    return "R9";
  endfunction

  task automatic run_seq(input logic [2:0] ba, input logic [14:0] ra, input logic [9:0] ca,
                         input bit interfere);
    int err0;
    build(ba, ra, ca);
    @(negedge clk);
    bank = ba; row = ra; col = ca; start = 1;
    @(negedge clk);
    start = 0;
    err0 = errors;
    for (int n = 0; n < NW; n++) begin
      chk("R2", {30'b0, busy, wr_en}, 32'h3);
      chk("R3", {22'b0, wr_addr}, {22'b0, START_ADDR + 10'(n)});
      chk(tag_of(n), wr_data, exp_w[n]);
      if (interfere && n == 100) begin
        start = 1; bank = ~ba; row = ~ra; col = ~ca;
      end
      if (interfere && n == 106) start = 0;
      @(negedge clk);
    end
    chk("R2", {30'b0, busy, wr_en}, 32'h0);
    if (interfere) begin
      checks++;
      if (errors != err0) begin
        errors++;
        $display("FAIL R10: actual %0d mismatches expected 0", errors - err0 - 1);
      end
    end
    @(negedge clk);
    chk("R2", {30'b0, busy, wr_en}, 32'h0);
  endtask

  task automatic test_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1", {30'b0, busy, wr_en}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {30'b0, busy, wr_en}, 32'h0);
  endtask

  initial begin
    test_reset();
    run_seq(3'd5, 15'h5A5A, 10'h3F8, 0);
    run_seq(3'd0, 15'h0000, 10'h000, 0);
    run_seq(3'd7, 15'h7FFF, 10'h155, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P*100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule